// File: doc/BRIEF.md
# Peripheral Bus Slave Register Bridge

This block is a slave on a shared on-chip peripheral bus. Its read data and responses are OR-combined with those of other slaves. The block decodes the bus address into a select for its own 32-byte window and a one-hot enable for each word slot in that window. The read enables are active only on reads, and the write enables only on writes. It then hands data, byte lanes and direction to a small set of user registers. It returns an acknowledge, an error or a retry to the bus. It raises a timeout-suppress output while a response is known to need more than eight cycles.

The master holds select, address, direction, byte lanes and write data until it sees acknowledge or retry. It then drops select for at least one cycle before the next access. Whenever select is low, every output is zero, so the block never disturbs the OR-combined bus.

The word slots in the window are:
- Slots 0 to 3: plain registers.
- Slot 4: a deliberately slow register.
- Slot 5: a one-word mailbox that can refuse an access with retry.
- Slots 6 and 7: unmapped.

Top module: `pbus_reg_bridge`

## Requirements
- R1: An access is in the window when bus_addr[31:5] equals BASE_ADDR[31:5]. The word slot is bus_addr[4:2]. Exactly one slot is touched per access, with read enables only on reads (bus_rnw=1) and write enables only on writes (bus_rnw=0). A read never alters a register.
- R2: An access to a plain register (slots 0-3) is acknowledged in the cycle after the first selected cycle. A read returns the register contents on sl_rdata in that acknowledge cycle. Every register resets to zero.
- R3: On a write, bus_be bit i set to 1 updates byte lane i (bits 8i+7:8i) of the target. Lanes whose bit is 0 keep their value, and bus_be=0 changes nothing.
- R4: A write acknowledge means the data has been stored, and a later read returns it.
- R5: An access to slot 6 or 7 is acknowledged with sl_err high in the same cycle. sl_err is never high without sl_ack.
- R6: The mailbox (slot 5) answers sl_retry, not sl_ack, on a write while full or a read while empty, and its state is left unchanged. A write while empty fills it, and a read while full returns the word and empties it. sl_ack and sl_retry are never high together.
- R7: The slow register (slot 4) is acknowledged 12 cycles after the first selected cycle.
- R8: sl_tout_sup is high in every cycle of a slow access from the first selected cycle up to the cycle before the acknowledge, and low otherwise. No response waits more than 8 cycles without it.
- R9: With bus_sel low, sl_rdata, sl_ack, sl_err, sl_retry and sl_tout_sup are all zero. sl_rdata is non-zero only in a read acknowledge cycle.
- R10: Each select period gets exactly one response. While select stays high after the response, the outputs stay zero and no register changes.
- R11: A selected access outside the window gets no response and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Master has a valid access on the bus |
| bus_addr | input | 32 | Byte address |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| sl_rdata | output | 32 | Read data, zero unless read acknowledge |
| sl_ack | output | 1 | Transfer acknowledge |
| sl_err | output | 1 | Error qualifier, valid with sl_ack |
| sl_retry | output | 1 | Access refused, master must reissue |
| sl_tout_sup | output | 1 | Suppress bus timeout, response is slow |

## Verification
Two functions can coincide on one edge:
- Acknowledge with error: the error flag and the acknowledge come from the same registered response. Unmapped-slot reads and writes are interleaved with plain accesses, and the error flag must appear only in the acknowledge cycle.
- Retry with a mailbox state change: on a retry edge the mailbox must not change. This is provoked by back-to-back mailbox writes and reads with only one idle cycle between them, and judged by whether the following access is retried or acknowledged and what data it returns.

On slow accesses, select is held past the acknowledge to check that timeout-suppress drops in exactly the acknowledge cycle and that no second response follows.

// File: rtl/pbus_bridge_pkg.sv
// Shared types for the peripheral bus register bridge.
// Assumes: a response is at most one of acknowledge or retry; error rides on acknowledge.
package pbus_bridge_pkg;

    typedef struct packed {
        logic ack;
        logic err;
        logic retry;
    } resp_t;

endpackage

// File: rtl/pbus_addr_decode.sv
// Address decoder: turns the bus select and address into a window select,
// a "still waiting for an answer" flag, and one-hot read/write slot enables.
// Assumes: the master holds select until it sees a response, then drops it
// for at least one cycle; resp_fire marks the cycle the answer is decided.
module pbus_addr_decode #(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          OFF_BITS  = 3,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_rnw,
    input  logic                    resp_fire,
    output logic                    blk_cs,
    output logic                    pending,
    output logic [(1<<OFF_BITS)-1:0] rd_ce,
    output logic [(1<<OFF_BITS)-1:0] wr_ce
);
    localparam int LANE_BITS = $clog2(DW / 8);
    localparam int NSLOT     = 1 << OFF_BITS;
    localparam int TAG_LO    = LANE_BITS + OFF_BITS;

    logic                answered_q;
    logic [OFF_BITS-1:0] slot;
    logic [AW-1:0]       base_full;
    logic                unused_lane_bits;

    assign base_full        = AW'(BASE_ADDR);
    assign unused_lane_bits = ^bus_addr[LANE_BITS-1:0];
    assign blk_cs  = bus_sel && (bus_addr[AW-1:TAG_LO] == base_full[AW-1:TAG_LO]);
    assign pending = blk_cs && !answered_q;
    assign slot    = bus_addr[LANE_BITS +: OFF_BITS];

    // Remember that this select period has been answered until select drops.
    always_ff @(posedge clk) begin
        if (!rst_n)          answered_q <= 1'b0;
        else if (!blk_cs)    answered_q <= 1'b0;
        else if (resp_fire)  answered_q <= 1'b1;
    end

    // One enable per word slot, split by direction.
    for (genvar i = 0; i < NSLOT; i++) begin : g_ce
        assign rd_ce[i] = pending &&  bus_rnw && (slot == OFF_BITS'(i));
        assign wr_ce[i] = pending && !bus_rnw && (slot == OFF_BITS'(i));
    end

    a_r1_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_ce, wr_ce}));
    a_r1_read_enable_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_ce) |-> bus_rnw);
    a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fire |=> !resp_fire);
endmodule

// File: rtl/pbus_user_regs.sv
// User-side register set behind the decoder. Slots: plain registers first,
// then one slow register, then a one-word mailbox; higher slots are holes.
// Decides the response in the cycle resp_fire is high and registers it.
// Assumes: enables are one-hot and stay high until the response fires.
module pbus_user_regs
    import pbus_bridge_pkg::*;
#(
    parameter int DW         = 32,
    parameter int OFF_BITS   = 3,
    parameter int NUM_REGS   = 4,
    parameter int SLOW_DELAY = 12,
    parameter int TOUT_LIMIT = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [(1<<OFF_BITS)-1:0] rd_ce,
    input  logic [(1<<OFF_BITS)-1:0] wr_ce,
    input  logic [DW/8-1:0]          bus_be,
    input  logic [DW-1:0]            bus_wdata,
    output logic                     resp_fire,
    output logic                     tout_sup,
    output resp_t                    resp_q,
    output logic [DW-1:0]            rdata_q
);
    localparam int NSLOT     = 1 << OFF_BITS;
    localparam int BE_W      = DW / 8;
    localparam int SLOW_SLOT = NUM_REGS;
    localparam int MBOX_SLOT = NUM_REGS + 1;
    localparam int CNT_W     = $clog2(SLOW_DELAY + 1);
    localparam logic [NSLOT-1:0] MAPPED = NSLOT'((1 << (NUM_REGS + 2)) - 1);

    logic [DW-1:0]    plain_q [NUM_REGS];
    logic [DW-1:0]    slow_q;
    logic [DW-1:0]    mbox_q;
    logic             mbox_full;
    logic [CNT_W-1:0] slow_cnt;
    logic [NSLOT-1:0] any_ce;
    logic             slow_sel, slow_fire, mbox_retry, hole_hit, plain_hit, is_read;
    logic [DW-1:0]    rd_word;

    // Apply byte-lane enables to a stored word.
    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [BE_W-1:0] be);
        logic [DW-1:0] res;
        res = old_w;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) res[8*b +: 8] = new_w[8*b +: 8];
        return res;
    endfunction

    assign any_ce     = rd_ce | wr_ce;
    assign is_read    = |rd_ce;
    assign plain_hit  = |any_ce[NUM_REGS-1:0];
    assign slow_sel   = any_ce[SLOW_SLOT];
    assign slow_fire  = slow_sel && (slow_cnt == CNT_W'(SLOW_DELAY - 1));
    assign hole_hit   = |(any_ce & ~MAPPED);
    assign mbox_retry = (wr_ce[MBOX_SLOT] && mbox_full) || (rd_ce[MBOX_SLOT] && !mbox_full);
    assign resp_fire  = plain_hit || slow_fire || any_ce[MBOX_SLOT] || hole_hit;

    // Plain registers: written once, on the single enabled cycle.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_plain
        always_ff @(posedge clk) begin
            if (!rst_n)        plain_q[i] <= '0;
            else if (wr_ce[i]) plain_q[i] <= lane_merge(plain_q[i], bus_wdata, bus_be);
        end
    end

    // Slow register wait counter: counts selected cycles until the answer.
    always_ff @(posedge clk) begin
        if (!rst_n)                      slow_cnt <= '0;
        else if (slow_sel && !slow_fire) slow_cnt <= slow_cnt + 1'b1;
        else                             slow_cnt <= '0;
    end

    // Slow register storage: written when its answer fires.
    always_ff @(posedge clk) begin
        if (!rst_n)                             slow_q <= '0;
        else if (wr_ce[SLOW_SLOT] && slow_fire) slow_q <= lane_merge(slow_q, bus_wdata, bus_be);
    end

    // Mailbox: fill on write while empty, drain on read while full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbox_q    <= '0;
            mbox_full <= 1'b0;
        end else if (wr_ce[MBOX_SLOT] && !mbox_full) begin
            mbox_q    <= lane_merge(mbox_q, bus_wdata, bus_be);
            mbox_full <= 1'b1;
        end else if (rd_ce[MBOX_SLOT] && mbox_full) begin
            mbox_full <= 1'b0;
        end
    end

    // Read data selection across the mapped slots.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_ce[i]) rd_word = plain_q[i];
        if (rd_ce[SLOW_SLOT]) rd_word = slow_q;
        if (rd_ce[MBOX_SLOT]) rd_word = mbox_q;
    end

    // Register the response and the read data for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q  <= '0;
            rdata_q <= '0;
        end else begin
            resp_q.ack   <= resp_fire && !mbox_retry;
            resp_q.err   <= hole_hit;
            resp_q.retry <= resp_fire && mbox_retry;
            rdata_q      <= (resp_fire && is_read && !mbox_retry) ? rd_word : '0;
        end
    end

    // Timeout suppress only exists when the slow answer exceeds the bus limit.
    if (SLOW_DELAY > TOUT_LIMIT) begin : g_tout
        assign tout_sup = slow_sel;
    end else begin : g_no_tout
        assign tout_sup = 1'b0;
    end

    a_r5_err_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        resp_q.err |-> resp_q.ack);
    a_r6_ack_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_q.ack && resp_q.retry));
    a_r6_retry_keeps_mailbox: assert property (@(posedge clk) disable iff (!rst_n)
        resp_q.retry |-> $stable(mbox_full) && $stable(mbox_q));
endmodule

// File: rtl/pbus_reg_bridge.sv
// Top of the peripheral bus slave register bridge. Joins the decoder and the
// user registers and forces every output to zero outside its own select, so
// the OR-combined bus is never disturbed.
// Assumes: master keeps the access stable until ack or retry.
module pbus_reg_bridge
    import pbus_bridge_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          DW         = 32,
    parameter int          OFF_BITS   = 3,
    parameter int          NUM_REGS   = 4,
    parameter int          SLOW_DELAY = 12,
    parameter int          TOUT_LIMIT = 8,
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rnw,
    input  logic [DW/8-1:0] bus_be,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   sl_rdata,
    output logic            sl_ack,
    output logic            sl_err,
    output logic            sl_retry,
    output logic            sl_tout_sup
);
    localparam int NSLOT = 1 << OFF_BITS;
    localparam int WAIT_W = $clog2(TOUT_LIMIT + 2);

    logic             blk_cs, pending, resp_fire, tout_raw;
    logic [NSLOT-1:0] rd_ce, wr_ce;
    resp_t            resp_q;
    logic [DW-1:0]    rdata_q;

    pbus_addr_decode #(
        .AW(AW), .DW(DW), .OFF_BITS(OFF_BITS), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_rnw(bus_rnw), .resp_fire(resp_fire), .blk_cs(blk_cs),
        .pending(pending), .rd_ce(rd_ce), .wr_ce(wr_ce)
    );

    pbus_user_regs #(
        .DW(DW), .OFF_BITS(OFF_BITS), .NUM_REGS(NUM_REGS),
        .SLOW_DELAY(SLOW_DELAY), .TOUT_LIMIT(TOUT_LIMIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_ce(rd_ce), .wr_ce(wr_ce),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .resp_fire(resp_fire),
        .tout_sup(tout_raw), .resp_q(resp_q), .rdata_q(rdata_q)
    );

    // Outputs exist only inside this slave's own select.
    assign sl_ack      = blk_cs && resp_q.ack;
    assign sl_err      = blk_cs && resp_q.err;
    assign sl_retry    = blk_cs && resp_q.retry;
    assign sl_rdata    = blk_cs ? rdata_q : '0;
    assign sl_tout_sup = blk_cs && pending && tout_raw;

    // Checker state: cycles waited without an answer in this select period.
    logic [WAIT_W-1:0] wait_cnt;
    logic              done_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !blk_cs) begin
            wait_cnt <= '0;
            done_q   <= 1'b0;
        end else if (sl_ack || sl_retry) begin
            done_q   <= 1'b1;
        end else if (!done_q && wait_cnt != WAIT_W'(TOUT_LIMIT + 1)) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    a_r8_long_wait_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cnt >= WAIT_W'(TOUT_LIMIT)) && !done_q && !sl_ack && !sl_retry |-> sl_tout_sup);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (sl_rdata == '0) && !sl_ack && !sl_err && !sl_retry && !sl_tout_sup);
    a_r9_data_only_on_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_rdata != '0) |-> sl_ack && bus_rnw);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sl_ack |=> !sl_ack);
endmodule

// File: tb/pbus_reg_bridge_tb.sv
`timescale 1ns/1ps
module pbus_reg_bridge_tb;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int SLOW_LAT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rnw = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] sl_rdata;
    logic        sl_ack, sl_err, sl_retry, sl_tout_sup;

    int vectors = 0;
    int misses  = 0;
    bit finished = 1'b0;

    // Behavioural reference state.
    logic [31:0] m_reg [6];
    logic [31:0] m_mbox;
    bit          m_full;

    always #4 clk = ~clk;

    pbus_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_rnw(bus_rnw), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .sl_rdata(sl_rdata), .sl_ack(sl_ack), .sl_err(sl_err),
        .sl_retry(sl_retry), .sl_tout_sup(sl_tout_sup)
    );

    task automatic check(input string tag, input logic [31:0] ed, input logic ea,
                         input logic ee, input logic er, input logic et);
        vectors++;
        if (sl_rdata !== ed || sl_ack !== ea || sl_err !== ee || sl_retry !== er ||
            sl_tout_sup !== et) begin
            misses++;
            $display("FAIL %s: got data=%h ack=%b err=%b retry=%b tsup=%b, want data=%h ack=%b err=%b retry=%b tsup=%b",
                     tag, sl_rdata, sl_ack, sl_err, sl_retry, sl_tout_sup, ed, ea, ee, er, et);
        end
    endtask

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    // One bus access, compared every cycle against the reference.
    task automatic access(input logic [31:0] a, input logic rn, input logic [3:0] be,
                          input logic [31:0] wd, input int hold, input string tag);
        bit          inblk = (a[31:5] == BASE[31:5]);
        int          slot  = int'(a[4:2]);
        int          lat   = (slot == 4) ? SLOW_LAT : 1;
        bit          e_ack = 0, e_err = 0, e_rty = 0;
        logic [31:0] e_dat = '0;
        if (inblk) begin
            if (slot <= 4) begin
                e_ack = 1;
                if (rn) e_dat = m_reg[slot];
            end else if (slot == 5) begin
                if (rn) begin
                    e_rty = !m_full; e_ack = m_full;
                    if (m_full) e_dat = m_mbox;
                end else begin
                    e_rty = m_full; e_ack = !m_full;
                end
            end else begin
                e_ack = 1; e_err = 1;
            end
        end
        @(negedge clk);
        bus_sel = 1; bus_addr = a; bus_rnw = rn; bus_be = be; bus_wdata = wd;
        #1;
        for (int k = 0; k <= (inblk ? lat : 0) + hold; k++) begin
            bit at = inblk && (k == lat);
            bit ts = inblk && (slot == 4) && (k < lat);
            string t = at ? tag : (ts ? "R8" : (k > lat ? "R10" : tag));
            if (!inblk) t = "R11";
            check(t, at ? e_dat : 32'h0, at & e_ack, at & e_err, at & e_rty, ts);
            @(posedge clk); @(negedge clk); #1;
        end
        if (inblk && !rn && e_ack && !e_err) begin
            if (slot <= 4) m_reg[slot] = merge(m_reg[slot], wd, be);
            else begin m_mbox = merge(m_mbox, wd, be); m_full = 1; end
        end
        if (inblk && rn && slot == 5 && e_ack) m_full = 0;
        bus_sel = 0; bus_wdata = 32'hDEAD_BEEF;
        #1 check("R9", 32'h0, 0, 0, 0, 0);
    endtask

    function automatic logic [31:0] ad(int slot);
        return BASE + 32'(slot * 4);
    endfunction

    initial begin
        for (int i = 0; i < 6; i++) m_reg[i] = '0;
        m_mbox = '0; m_full = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 check("R9", 32'h0, 0, 0, 0, 0);
        rst_n = 1;
        // R2: reset contents and one-cycle acknowledge.
        for (int i = 0; i < 4; i++) access(ad(i), 1, 4'hF, '0, 0, "R2");
        // R1/R4: distinct data into each plain register, read back each.
        for (int i = 0; i < 4; i++) access(ad(i), 0, 4'hF, 32'h1000_0001 * (i + 3), 0, "R4");
        for (int i = 0; i < 4; i++) access(ad(i), 1, 4'hF, 32'hFFFF_FFFF, 0, "R1");
        // R3: byte lanes.
        access(ad(2), 0, 4'b0101, 32'h1122_3344, 0, "R3");
        access(ad(2), 1, 4'hF, '0, 0, "R3");
        access(ad(2), 0, 4'b1000, 32'hFF00_0000, 1, "R3");
        access(ad(2), 0, 4'b0000, 32'h0BAD_0BAD, 0, "R3");
        access(ad(2), 1, 4'hF, '0, 0, "R3");
        // R5: holes answered with error.
        access(ad(6), 1, 4'hF, '0, 0, "R5");
        access(ad(7), 0, 4'hF, 32'h7777_7777, 1, "R5");
        access(ad(1), 1, 4'hF, '0, 0, "R5");
        // R6: mailbox retry and state.
        access(ad(5), 1, 4'hF, '0, 0, "R6");
        access(ad(5), 0, 4'hF, 32'h0000_0055, 0, "R6");
        access(ad(5), 0, 4'hF, 32'h0000_0066, 0, "R6");
        access(ad(5), 1, 4'hF, '0, 1, "R6");
        access(ad(5), 1, 4'hF, '0, 0, "R6");
        // R7/R8/R10: slow register, select held past the answer.
        access(ad(4), 0, 4'hF, 32'hCAFE_F00D, 2, "R7");
        access(ad(4), 1, 4'hF, '0, 3, "R7");
        access(ad(0), 1, 4'hF, '0, 3, "R10");
        // R11: outside the window.
        access(BASE + 32'h20, 0, 4'hF, 32'h1234_5678, 3, "R11");
        access(32'h5000_0004, 0, 4'hF, 32'h1234_5678, 3, "R11");
        access(ad(1), 1, 4'hF, '0, 0, "R11");
        access(ad(0), 1, 4'hF, '0, 0, "R11");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++; misses++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule